// File: doc/BRIEF.md
# Pin-Strap Configuration Scanner

This block runs once after reset is released and discovers how four strap inputs are wired to seven program-select lines. It raises one select line at a time, in order, holds it for a settle interval and samples all four straps. A strap that reads high while a line is raised is recorded as tied to that line. After the last line it stops driving the shared pins and decodes each strap's line into configuration settings. The settings are an output pulse format and full-scale rate, a current-channel gain with high-pass filter enables, and a signed gain trim.

The trim is the sum of a coarse step (strap 3) and a fine step (strap 2), in units of 0.2 %. A strap tied to no line, or to more than one, sets an error flag, and the whole configuration then falls back to safe defaults. The results are registered, marked valid, and held unchanged until the next reset. Strap bit positions are: bit 0 rate select, bit 1 gain select, bit 2 fine trim, bit 3 coarse trim. Select line Pn is bit n-1 of `sel_drive`.

Top module: `strap_scan`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `sel_drive` is 0, `sel_oe` is 0, `cfg_valid` and `cfg_err` are 0, and the settings hold their defaults: `pulse_mech`=0, `rate_qhz`=1, `gain_hi`=0, `hpf_i`=0, `hpf_v`=0, `trim`=0.
- R2: From the second cycle after reset release, lines P1 to P7 are raised in that order. Each line is raised alone, with `sel_oe` high, for `SETTLE_CYC` consecutive cycles.
- R3: After the P7 interval there is one cycle with `sel_oe` low and `sel_drive` 0. Then `cfg_valid` rises and stays high until reset.
- R4: A strap is tied to line Pn when its input reads high while Pn is raised. When every strap is tied to exactly one line, `cfg_err` stays 0.
- R5: The rate strap on P1 to P5 gives `pulse_mech`=0 with `rate_qhz` (rate in quarter-hertz) 1, 2, 4, 8 and 16. P6 gives `pulse_mech`=1 with `rate_qhz`=8. P7 gives `pulse_mech`=1 with `rate_qhz`=64.
- R6: The gain strap sets (`gain_hi`, `hpf_i`, `hpf_v`) as follows: P1 (0,0,0), P2 (1,0,0), P3 (0,1,1), P4 (1,1,1), P5 (0,1,0), P6 (1,1,0), P7 (0,0,1). `gain_hi`=1 means 50x and 0 means 10x.
- R7: With the coarse strap on Pc and the fine strap on Pf, `trim` = 7*(4-c) + (4-f) as a 6-bit two's-complement value in 0.2 % steps. It always lies within -24 to +24.
- R8: If any strap is tied to zero lines or to more than one, `cfg_err`=1 and all settings take the R1 defaults. `cfg_valid` still rises at the R3 time.
- R9: Once `cfg_valid` is high, no select line is driven, and changes on the strap inputs have no effect on any output.
- R10: Asserting `rst_n` at any point, including during a scan, clears the outputs to the R1 state, and releasing it starts a fresh scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_in | input | 4 | Strap levels: bit 0 rate, 1 gain, 2 fine trim, 3 coarse trim |
| sel_drive | output | 7 | Program-select levels, bit n-1 is Pn |
| sel_oe | output | 1 | High while the shared select pins are driven |
| cfg_valid | output | 1 | Settings decoded and latched |
| cfg_err | output | 1 | Strap wiring was not one-to-one |
| pulse_mech | output | 1 | 1 = counter pulse format, 0 = stepper format |
| rate_qhz | output | 7 | Full-scale pulse rate in units of 0.25 Hz |
| gain_hi | output | 1 | Current channel at 50x (1) or 10x (0) |
| hpf_i | output | 1 | Current-channel high-pass filter enabled |
| hpf_v | output | 1 | Voltage-channel high-pass filter enabled |
| trim | output | 6 | Signed gain trim in units of 0.2 % |

## Verification
The assertions assume that each strap level depends only on which select line is raised. They also assume that the wiring does not change during a scan, except through a reset. The bench models each strap as the OR of the raised lines in its tie mask. It changes those masks only while reset is held or after `cfg_valid` is high, and the late changes exercise R9. Open and double-tied straps drive the error path of R8. A reset asserted in the middle of a scan checks that the restart in R10 begins from line P1.

// File: rtl/strap_scan_pkg.sv
package strap_scan_pkg;

   localparam int NSEL     = 7;
   localparam int NSTRAP   = 4;
   localparam int IDX_W    = $clog2(NSEL);
   localparam int RATE_W   = 7;
   localparam int TRIM_W   = 6;
   localparam int TRIM_MAX = 24;

   localparam int IX_RATE   = 0;
   localparam int IX_GAIN   = 1;
   localparam int IX_FINE   = 2;
   localparam int IX_COARSE = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_LATCH = 2'd2,
      ST_DONE  = 2'd3
   } scan_st_e;

   typedef struct packed {
      logic                     mech;
      logic [RATE_W-1:0]        rate_qhz;
      logic                     gain_hi;
      logic                     hpf_i;
      logic                     hpf_v;
      logic signed [TRIM_W-1:0] trim;
   } cfg_t;

   localparam cfg_t CFG_DEFAULT = '{
      mech:     1'b0,
      rate_qhz: 7'd1,
      gain_hi:  1'b0,
      hpf_i:    1'b0,
      hpf_v:    1'b0,
      trim:     6'sd0
   };

   function automatic logic [IDX_W-1:0] line_index(input logic [NSEL-1:0] row);
      logic [IDX_W-1:0] r;
      r = '0;
      for (int i = 0; i < NSEL; i++)
         if (row[i]) r = IDX_W'(i);
      return r;
   endfunction

   function automatic logic single_tie(input logic [NSEL-1:0] row);
      int n;
      n = 0;
      for (int i = 0; i < NSEL; i++)
         n += int'(row[i]);
      return (n == 1);
   endfunction

   // stepper rates double per line; the last two lines select counter format
   function automatic logic [RATE_W:0] rate_decode(input logic [IDX_W-1:0] idx);
      logic             mech;
      logic [RATE_W-1:0] rate;
      mech = 1'b0;
      rate = 7'd1;
      case (idx)
         3'd5:    begin mech = 1'b1; rate = 7'd8;  end
         3'd6:    begin mech = 1'b1; rate = 7'd64; end
         default: begin mech = 1'b0; rate = RATE_W'(7'd1 << idx); end
      endcase
      return {mech, rate};
   endfunction

   // returns {gain_hi, hpf_i, hpf_v}
   function automatic logic [2:0] gain_decode(input logic [IDX_W-1:0] idx);
      logic [2:0] g;
      case (idx)
         3'd0:    g = 3'b000;
         3'd1:    g = 3'b100;
         3'd2:    g = 3'b011;
         3'd3:    g = 3'b111;
         3'd4:    g = 3'b010;
         3'd5:    g = 3'b110;
         default: g = 3'b001;
      endcase
      return g;
   endfunction

   function automatic logic signed [TRIM_W-1:0] trim_decode(
      input logic [IDX_W-1:0] coarse_idx,
      input logic [IDX_W-1:0] fine_idx);
      int centre;
      int t;
      centre = (NSEL - 1) / 2;
      t = 7 * (centre - int'(coarse_idx)) + (centre - int'(fine_idx));
      return TRIM_W'(t);
   endfunction

endpackage

// File: rtl/strap_scan_seq.sv
module strap_scan_seq
   import strap_scan_pkg::*;
#(
   parameter int SETTLE_CYC = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   output scan_st_e         state,
   output logic [IDX_W-1:0] line_idx,
   output logic             sample_stb,
   output logic [NSEL-1:0]  drive
);

   localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [IDX_W-1:0] LINE_LAST = IDX_W'(NSEL - 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
   endgenerate

   scan_st_e         st_q;
   logic [IDX_W-1:0] li_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (st_q == ST_SCAN) && (cnt_q == CNT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         li_q  <= '0;
         cnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               st_q  <= ST_SCAN;
               li_q  <= '0;
               cnt_q <= '0;
            end
            ST_SCAN: begin
               if (at_end) begin
                  cnt_q <= '0;
                  if (li_q == LINE_LAST) st_q <= ST_LATCH;
                  else                   li_q <= li_q + 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_LATCH: st_q <= ST_DONE;
            default:  st_q <= ST_DONE;
         endcase
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSEL; gi++) begin : g_line
         assign drive[gi] = (st_q == ST_SCAN) && (li_q == IDX_W'(gi));
      end
   endgenerate

   assign state      = st_q;
   assign line_idx   = li_q;
   assign sample_stb = at_end;

   AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(li_q) < NSEL) else $error("line index out of range");            // R2
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt_q) < SETTLE_CYC) else $error("settle counter overran");       // R2
   AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && li_q != LINE_LAST) |=> (li_q == $past(li_q) + 1'b1))
      else $error("line did not advance");                                    // R2

endmodule

// File: rtl/strap_scan_capture.sv
module strap_scan_capture
   import strap_scan_pkg::*;
#(
   parameter int SYNC_STAGES = 2
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NSTRAP-1:0]            strap_in,
   input  logic                         sample_stb,
   input  logic [IDX_W-1:0]             line_idx,
   output logic [NSTRAP-1:0][NSEL-1:0]  match
);

   logic [NSTRAP-1:0] strap_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign strap_s = strap_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0][NSTRAP-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '0;
            end else begin
               chain_q[0] <= strap_in;
               for (int i = 1; i < SYNC_STAGES; i++)
                  chain_q[i] <= chain_q[i-1];
            end
         end
         assign strap_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   genvar gs;
   generate
      for (gs = 0; gs < NSTRAP; gs++) begin : g_strap
         logic [NSEL-1:0] row_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (sample_stb) begin
               for (int i = 0; i < NSEL; i++)
                  if (line_idx == IDX_W'(i)) row_q[i] <= strap_s[gs];
            end
         end
         assign match[gs] = row_q;
      end
   endgenerate

endmodule

// File: rtl/strap_scan_decode.sv
module strap_scan_decode
   import strap_scan_pkg::*;
(
   input  logic [NSTRAP-1:0][NSEL-1:0] match,
   output cfg_t                        cfg,
   output logic                        wiring_err
);

   logic [NSTRAP-1:0]            ok;
   logic [NSTRAP-1:0][IDX_W-1:0] idx;

   genvar gs;
   generate
      for (gs = 0; gs < NSTRAP; gs++) begin : g_row
         assign ok[gs]  = single_tie(match[gs]);
         assign idx[gs] = line_index(match[gs]);
      end
   endgenerate

   assign wiring_err = ~&ok;

   always_comb begin
      logic [RATE_W:0] r;
      logic [2:0]      g;
      r = rate_decode(idx[IX_RATE]);
      g = gain_decode(idx[IX_GAIN]);
      if (wiring_err) begin
         cfg = CFG_DEFAULT;
      end else begin
         cfg.mech     = r[RATE_W];
         cfg.rate_qhz = r[RATE_W-1:0];
         cfg.gain_hi  = g[2];
         cfg.hpf_i    = g[1];
         cfg.hpf_v    = g[0];
         cfg.trim     = trim_decode(idx[IX_COARSE], idx[IX_FINE]);
      end
   end

endmodule

// File: rtl/strap_scan.sv
module strap_scan
   import strap_scan_pkg::*;
#(
   parameter int SETTLE_CYC  = 4,
   parameter int SYNC_STAGES = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [3:0]               strap_in,
   output logic [6:0]               sel_drive,
   output logic                     sel_oe,
   output logic                     cfg_valid,
   output logic                     cfg_err,
   output logic                     pulse_mech,
   output logic [6:0]               rate_qhz,
   output logic                     gain_hi,
   output logic                     hpf_i,
   output logic                     hpf_v,
   output logic signed [5:0]        trim
);

   generate
      if (SETTLE_CYC <= SYNC_STAGES) begin : g_bad_timing
         $error("SETTLE_CYC must exceed SYNC_STAGES");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   scan_st_e                    st;
   logic [IDX_W-1:0]            line_idx;
   logic                        sample_stb;
   logic [NSEL-1:0]             drive;
   logic [NSTRAP-1:0][NSEL-1:0] match;
   cfg_t                        cfg_dec;
   logic                        err_dec;

   strap_scan_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .state      (st),
      .line_idx   (line_idx),
      .sample_stb (sample_stb),
      .drive      (drive)
   );

   strap_scan_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_in   (strap_in),
      .sample_stb (sample_stb),
      .line_idx   (line_idx),
      .match      (match)
   );

   strap_scan_decode u_dec (
      .match      (match),
      .cfg        (cfg_dec),
      .wiring_err (err_dec)
   );

   cfg_t cfg_q;
   logic valid_q;
   logic err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= CFG_DEFAULT;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else if (st == ST_LATCH) begin
         cfg_q   <= cfg_dec;
         valid_q <= 1'b1;
         err_q   <= err_dec;
      end
   end

   assign sel_drive  = drive;
   assign sel_oe     = (st == ST_SCAN);
   assign cfg_valid  = valid_q;
   assign cfg_err    = err_q;
   assign pulse_mech = cfg_q.mech;
   assign rate_qhz   = cfg_q.rate_qhz;
   assign gain_hi    = cfg_q.gain_hi;
   assign hpf_i      = cfg_q.hpf_i;
   assign hpf_v      = cfg_q.hpf_v;
   assign trim       = cfg_q.trim;

   AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_oe |-> $onehot(sel_drive)) else $error("not one line raised");      // R2
   AST_NO_STRAY_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_oe |-> (sel_drive == '0)) else $error("line raised while released"); // R3
   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> cfg_valid) else $error("valid dropped");                   // R3
   AST_RELEASED_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |-> !sel_oe) else $error("pins driven after decode");          // R9
   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> $stable({pulse_mech, rate_qhz, gain_hi, hpf_i, hpf_v, trim, cfg_err}))
      else $error("settings moved after decode");                              // R9
   AST_TRIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (trim >= -6'sd24) && (trim <= 6'sd24)) else $error("trim out of range"); // R7
   AST_ERR_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (trim == 6'sd0 && rate_qhz == 7'd1 && !pulse_mech && !gain_hi && !hpf_i && !hpf_v))
      else $error("error without defaults");                                   // R8
   AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> cfg_valid) else $error("error flag before decode");          // R8

endmodule

// File: tb/strap_scan_tb.sv
module strap_scan_tb;

   localparam int S      = 4;
   localparam int NL     = 7;
   localparam int T_REL  = NL * S + 1;
   localparam int T_VAL  = NL * S + 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  strap_in;
   logic [6:0]  sel_drive;
   logic        sel_oe, cfg_valid, cfg_err, pulse_mech, gain_hi, hpf_i, hpf_v;
   logic [6:0]  rate_qhz;
   logic signed [5:0] trim;

   logic [6:0] tie [4];

   int checks = 0;
   int errors = 0;
   int k = 0;
   int scen = 0;
   bit late_change = 0;
   bit cmp_en = 0;
   bit done = 0;

   int e_mech, e_rate, e_gain, e_hi, e_hv, e_trim, e_err;

   always #10 clk = ~clk;

   always_comb
      for (int s = 0; s < 4; s++) strap_in[s] = |(sel_drive & tie[s]);

   strap_scan #(.SETTLE_CYC(S), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .strap_in(strap_in),
      .sel_drive(sel_drive), .sel_oe(sel_oe), .cfg_valid(cfg_valid),
      .cfg_err(cfg_err), .pulse_mech(pulse_mech), .rate_qhz(rate_qhz),
      .gain_hi(gain_hi), .hpf_i(hpf_i), .hpf_v(hpf_v), .trim(trim)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (scenario %0d, cycle %0d)",
                  tag, act, exp, scen, k);
      end
   endtask

   function automatic int ones(input logic [6:0] m);
      int n = 0;
      for (int i = 0; i < 7; i++) n += int'(m[i]);
      return n;
   endfunction

   function automatic int pos(input logic [6:0] m);
      int p = 0;
      for (int i = 0; i < 7; i++) if (m[i]) p = i + 1;
      return p;
   endfunction

   // expected settings from the requirement tables, using line numbers 1..7
   task automatic compute_expect();
      int lr, lg, lf, lc;
      e_err = 0;
      for (int s = 0; s < 4; s++) if (ones(tie[s]) != 1) e_err = 1;
      lr = pos(tie[0]); lg = pos(tie[1]); lf = pos(tie[2]); lc = pos(tie[3]);
      if (e_err != 0) begin
         e_mech = 0; e_rate = 1; e_gain = 0; e_hi = 0; e_hv = 0; e_trim = 0;
      end else begin
         case (lr)
            6: begin e_mech = 1; e_rate = 8; end
            7: begin e_mech = 1; e_rate = 64; end
            default: begin e_mech = 0; e_rate = 2 ** (lr - 1); end
         endcase
         case (lg)
            1: begin e_gain = 0; e_hi = 0; e_hv = 0; end
            2: begin e_gain = 1; e_hi = 0; e_hv = 0; end
            3: begin e_gain = 0; e_hi = 1; e_hv = 1; end
            4: begin e_gain = 1; e_hi = 1; e_hv = 1; end
            5: begin e_gain = 0; e_hi = 1; e_hv = 0; end
            6: begin e_gain = 1; e_hi = 1; e_hv = 0; end
            default: begin e_gain = 0; e_hi = 0; e_hv = 1; end
         endcase
         e_trim = 7 * (4 - lc) + (4 - lf);
      end
   endtask

   always @(posedge clk or negedge rst_n)
      if (!rst_n) k <= 0; else k <= k + 1;

   // reference comparison every cycle
   always @(negedge clk) begin
      if (cmp_en) begin
         int exp_oe, exp_drv, exp_val;
         string tv, tc;
         if (!rst_n) begin
            chk("R1", int'(sel_oe), 0);
            chk("R1", int'(sel_drive), 0);
            chk("R1", int'(cfg_valid), 0);
            chk("R1", int'(cfg_err), 0);
            chk("R1", int'($signed(trim)), 0);
            chk("R1", int'(rate_qhz), 1);
         end else begin
            exp_oe  = (k >= 1 && k <= NL * S) ? 1 : 0;
            exp_drv = exp_oe ? (1 << ((k - 1) / S)) : 0;
            exp_val = (k >= T_VAL) ? 1 : 0;
            tv = (k == 0) ? "R1" : (late_change ? "R9" : "R2");
            chk(tv, int'(sel_oe), exp_oe);
            chk(tv, int'(sel_drive), exp_drv);
            tv = (k <= T_REL && scen > 0) ? "R10" : "R3";
            chk(tv, int'(cfg_valid), exp_val);
            if (exp_val != 0) begin
               chk(e_err ? "R8" : "R4", int'(cfg_err), e_err);
               tc = late_change ? "R9" : (e_err ? "R8" : "R5");
               chk(tc, int'(pulse_mech), e_mech);
               chk(tc, int'(rate_qhz), e_rate);
               tc = late_change ? "R9" : (e_err ? "R8" : "R6");
               chk(tc, int'(gain_hi), e_gain);
               chk(tc, int'(hpf_i), e_hi);
               chk(tc, int'(hpf_v), e_hv);
               tc = late_change ? "R9" : (e_err ? "R8" : "R7");
               chk(tc, int'($signed(trim)), e_trim);
            end else begin
               chk("R1", int'(cfg_err), 0);
               chk("R1", int'($signed(trim)), 0);
               chk("R1", int'(rate_qhz), 1);
               chk("R1", int'(gain_hi), 0);
            end
         end
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   // lines are given as 1..7, 0 means open; extra adds a second tie for strap 3
   task automatic scenario(input int lr, input int lg, input int lf, input int lc,
                           input int extra_coarse);
      @(posedge clk); #5;
      rst_n = 1'b0;
      late_change = 0;
      tie[0] = (lr > 0) ? 7'(1 << (lr - 1)) : 7'd0;
      tie[1] = (lg > 0) ? 7'(1 << (lg - 1)) : 7'd0;
      tie[2] = (lf > 0) ? 7'(1 << (lf - 1)) : 7'd0;
      tie[3] = (lc > 0) ? 7'(1 << (lc - 1)) : 7'd0;
      if (extra_coarse > 0) tie[3] = tie[3] | 7'(1 << (extra_coarse - 1));
      compute_expect();
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(T_VAL + 4);
      // R9: rewire every strap after decode; outputs must not move
      late_change = 1;
      for (int s = 0; s < 4; s++) tie[s] = 7'h7F;
      wait_cyc(12);
      scen++;
   endtask

   initial begin
      for (int s = 0; s < 4; s++) tie[s] = 7'd0;
      cmp_en = 1;
      wait_cyc(4);
      scenario(4, 5, 4, 4, 0);   // stepper 2 Hz, 10x current filter, trim 0
      scenario(1, 2, 1, 1, 0);   // trim +24
      scenario(7, 7, 7, 7, 0);   // counter 16 Hz, trim -24
      scenario(6, 3, 2, 2, 0);   // counter low rate, trim +16
      scenario(5, 4, 3, 5, 0);   // trim -6
      scenario(2, 6, 6, 3, 0);   // trim +5
      scenario(3, 1, 5, 6, 0);   // trim -15
      scenario(4, 5, 0, 4, 0);   // R8: open fine strap
      scenario(4, 5, 4, 2, 6);   // R8: coarse strap on two lines
      // R10: reset in the middle of a scan, then a full clean scan
      @(posedge clk); #5;
      rst_n = 1'b0;
      tie[0] = 7'b0000010; tie[1] = 7'b0000001; tie[2] = 7'b1000000; tie[3] = 7'b0000001;
      compute_expect();
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(10);
      rst_n = 1'b0;
      wait_cyc(2);
      rst_n = 1'b1;
      wait_cyc(T_VAL + 4);
      scen++;
      cmp_en = 0;
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule